// File: doc/BRIEF.md
# System Interrupt Flag and Line Controller

This block keeps the system-level interrupt flags of a message controller and drives its two interrupt request lines. Three flags exist per line: a transmit-abort flag, a lost-receive flag and a mailbox summary flag. The mailbox summary flag mirrors a pending indication from the mailbox router, which sits outside this block. A single line-select input steers each new abort or lost event into the flag set of line 0 or of line 1. The CPU clears flags by writing ones to a flag set. A line that still has enabled flags pending after a clear drops for one cycle and then comes back, so an edge-sensitive interrupt controller sees a fresh request.

The abort flag also clears itself once every per-mailbox abort-acknowledge bit, held elsewhere, reads zero. The lost flag is cleared only by its own write-1-to-clear. There is no data stream through this block: every pin is plain control or status, sampled on the rising clock edge. Flags and lines update at the edge where their cause is sampled.

Top module: `sysint_line_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, both flag sets read 0 and both lines are low.
- R2: An event sampled with `level_sel`=0 sets a bit only in `flags0`, and one sampled with `level_sel`=1 sets a bit only in `flags1`. The bit is visible after that same edge. Flag bit 0 is abort, bit 1 is lost and bit 2 is mailbox.
- R3: A line is high while any enabled flag of its set is 1. It goes low at the edge where its last enabled flag is cleared.
- R4: When a clear takes away at least one set flag of a line while other enabled flags stay pending, the line is low for exactly one cycle and then high again.
- R5: A flag sets whatever its mask says. `abort_mask` gates bit 0 and `lost_mask` gates bit 1 on both lines, and a masked flag never drives a line high. The mailbox bit is always enabled.
- R6: The abort flag of either set clears at the edge where the OR of all `abort_ack_bits` is 0. It can also be cleared by writing 1 to bit 0.
- R7: The lost flag stays set whatever `abort_ack_bits` do. It clears only when 1 is written to bit 1 of its own set.
- R8: `flags0[2]` and `flags1[2]` follow `mbx_pend[0]` and `mbx_pend[1]` one edge later. Writing 1 to bit 2 has no effect on them.
- R9: A set event and a write-1-to-clear of the same flag in the same cycle leave the flag set.
- R10: A clear write to a bit that is 0, or to the other line's set, leaves flags and lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| level_sel | input | 1 | Steers system events: 0 selects line 0, 1 selects line 1 |
| abort_mask | input | 1 | Enables the abort flag onto the lines |
| lost_mask | input | 1 | Enables the lost flag onto the lines |
| abort_evt | input | 1 | One-cycle pulse: a transmit abort was acknowledged |
| lost_evt | input | 1 | One-cycle pulse: a received message was lost |
| abort_ack_bits | input | NUM_MBOX | Per-mailbox abort-acknowledge bits |
| mbx_pend | input | 2 | Mailbox interrupt pending from the router, one bit per line |
| clr_wr | input | 1 | Write strobe for a flag clear |
| clr_line | input | 1 | Flag set addressed by the clear: 0 or 1 |
| clr_bits | input | 3 | Write-1-to-clear data |
| flags0 | output | 3 | Flag set of line 0 |
| flags1 | output | 3 | Flag set of line 1 |
| irq0 | output | 1 | Interrupt request line 0 |
| irq1 | output | 1 | Interrupt request line 1 |

## Verification
The bench builds the block with the default `NUM_MBOX` of 32. It drives the acknowledge vector with only the top bit or only the bottom bit set, which shows that the auto-clear watches the full width and not one end of it. With two lines, both steering directions, cross-line clears and the one-cycle re-trigger gap can all be reached within a few dozen cycles.

// File: rtl/sysint_pkg.sv
package sysint_pkg;
  localparam int FLAG_W  = 3;
  localparam int LINES   = 2;
  localparam int F_ABT   = 0;
  localparam int F_LOST  = 1;
  localparam int F_MBX   = 2;

  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/sysint_flag_bank.sv
module sysint_flag_bank
  import sysint_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_abt,
  input  logic      set_lost,
  input  logic      ack_any,
  input  logic      mbx_pend,
  input  logic      wr_en,
  input  flag_vec_t wr_bits,
  output flag_vec_t flags_d,
  output flag_vec_t flags_q,
  output logic      clr_hit
);

  flag_vec_t w1c;

  always_comb begin
    w1c = wr_en ? wr_bits : '0;
    // a set event wins over a same-cycle clear
    flags_d[F_ABT]  = set_abt  | (flags_q[F_ABT] & ack_any & ~w1c[F_ABT]);
    flags_d[F_LOST] = set_lost | (flags_q[F_LOST] & ~w1c[F_LOST]);
    // mailbox summary is owned by the router and ignores clears here
    flags_d[F_MBX]  = mbx_pend;
    clr_hit         = |(flags_q & ~flags_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R9
  set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_lost |=> flags_q[F_LOST]);

  // R7
  lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[F_LOST] && !(wr_en && wr_bits[F_LOST]) |=> flags_q[F_LOST]);

  // R6
  abt_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_any && !set_abt |=> !flags_q[F_ABT]);

endmodule

// File: rtl/sysint_line_drv.sv
module sysint_line_drv
  import sysint_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t flags_d,
  input  flag_vec_t flags_q,
  input  flag_vec_t en_mask,
  input  logic      clr_hit,
  output logic      irq_q
);

  logic pend_d;

  always_comb pend_d = |(flags_d & en_mask);

  // a clear with flags left pending forces one low cycle
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_d & ~clr_hit;
  end

  // R4
  retrig_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && irq_q |=> !irq_q);

  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> |(flags_q & $past(en_mask)));

endmodule

// File: rtl/sysint_line_ctrl.sv
module sysint_line_ctrl
  import sysint_pkg::*;
#(
  parameter int NUM_MBOX = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                level_sel,
  input  logic                abort_mask,
  input  logic                lost_mask,
  input  logic                abort_evt,
  input  logic                lost_evt,
  input  logic [NUM_MBOX-1:0] abort_ack_bits,
  input  logic [1:0]          mbx_pend,
  input  logic                clr_wr,
  input  logic                clr_line,
  input  logic [2:0]          clr_bits,
  output logic [2:0]          flags0,
  output logic [2:0]          flags1,
  output logic                irq0,
  output logic                irq1
);

  logic      ack_any;
  flag_vec_t en_mask;
  flag_vec_t fl_d [LINES];
  flag_vec_t fl_q [LINES];
  logic      hit  [LINES];
  logic      irq  [LINES];

  always_comb begin
    ack_any         = |abort_ack_bits;
    en_mask         = '0;
    en_mask[F_ABT]  = abort_mask;
    en_mask[F_LOST] = lost_mask;
    en_mask[F_MBX]  = 1'b1;
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic sel;
    assign sel = (level_sel == 1'(l));

    sysint_flag_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_abt  (abort_evt & sel),
      .set_lost (lost_evt & sel),
      .ack_any  (ack_any),
      .mbx_pend (mbx_pend[l]),
      .wr_en    (clr_wr & (clr_line == 1'(l))),
      .wr_bits  (clr_bits),
      .flags_d  (fl_d[l]),
      .flags_q  (fl_q[l]),
      .clr_hit  (hit[l])
    );

    sysint_line_drv u_drv (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_d (fl_d[l]),
      .flags_q (fl_q[l]),
      .en_mask (en_mask),
      .clr_hit (hit[l]),
      .irq_q   (irq[l])
    );
  end

  assign flags0 = fl_q[0];
  assign flags1 = fl_q[1];
  assign irq0   = irq[0];
  assign irq1   = irq[1];

  // R2
  steer0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt && !level_sel |=> flags0[F_ABT]);

  // R2
  steer1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_evt && level_sel |=> flags1[F_LOST]);

endmodule

// File: tb/sysint_line_ctrl_test.sv
module sysint_line_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NMB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic level_sel = 1'b0, abort_mask = 1'b1, lost_mask = 1'b1;
  logic abort_evt = 1'b0, lost_evt = 1'b0;
  logic [NMB-1:0] abort_ack_bits = '0;
  logic [1:0] mbx_pend = '0;
  logic clr_wr = 1'b0, clr_line = 1'b0;
  logic [2:0] clr_bits = '0;
  logic [2:0] flags0, flags1;
  logic irq0, irq1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] f0;
    logic [2:0] f1;
    logic       i0;
    logic       i1;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysint_line_ctrl #(.NUM_MBOX(NMB)) uut (
    .clk(clk), .rst_n(rst_n), .level_sel(level_sel),
    .abort_mask(abort_mask), .lost_mask(lost_mask),
    .abort_evt(abort_evt), .lost_evt(lost_evt),
    .abort_ack_bits(abort_ack_bits), .mbx_pend(mbx_pend),
    .clr_wr(clr_wr), .clr_line(clr_line), .clr_bits(clr_bits),
    .flags0(flags0), .flags1(flags1), .irq0(irq0), .irq1(irq1)
  );

  task automatic cmp(input exp_t e);
    checks++;
    if (flags0 !== e.f0 || flags1 !== e.f1 || irq0 !== e.i0 || irq1 !== e.i1) begin
      errors++;
      $display("FAIL %s: got f0=%b f1=%b i0=%b i1=%b exp f0=%b f1=%b i0=%b i1=%b",
               e.tag, flags0, flags1, irq0, irq1, e.f0, e.f1, e.i0, e.i1);
    end
  endtask

  // driver: inputs at the falling edge, expectation for the next rising edge
  task automatic step(input logic am, input logic lm, input logic lvl,
                      input logic abt, input logic lst, input logic [NMB-1:0] ack,
                      input logic [1:0] mbx, input logic wr, input logic wl,
                      input logic [2:0] wd, input logic [2:0] ef0,
                      input logic [2:0] ef1, input logic ei0, input logic ei1,
                      input string tag);
    exp_t e;
    @(negedge clk);
    abort_mask = am; lost_mask = lm; level_sel = lvl;
    abort_evt = abt; lost_evt = lst; abort_ack_bits = ack;
    mbx_pend = mbx; clr_wr = wr; clr_line = wl; clr_bits = wd;
    e.f0 = ef0; e.f1 = ef1; e.i0 = ei0; e.i1 = ei1; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) cmp(sb.pop_front());
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [NMB-1:0] ACK_HI = {1'b1, {(NMB-1){1'b0}}};
  localparam logic [NMB-1:0] ACK_LO = {{(NMB-1){1'b0}}, 1'b1};
  localparam logic [NMB-1:0] ACK_0  = '0;

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    e.f0 = '0; e.f1 = '0; e.i0 = 1'b0; e.i1 = 1'b0; e.tag = "R1 in reset";
    cmp(e);
    @(negedge clk);
    rst_n = 1'b1;
    // am lm lvl abt lst ack mbx wr wl wd | f0 f1 i0 i1
    step(1,1,0,0,0,ACK_0 ,2'b00,0,0,3'b000, 3'b000,3'b000,0,0, "R1 after release");
    step(1,1,0,1,0,ACK_HI,2'b00,0,0,3'b000, 3'b001,3'b000,1,0, "R2 R5 abort to line0");
    step(1,1,0,0,0,ACK_HI,2'b00,0,0,3'b000, 3'b001,3'b000,1,0, "R6 abort held by ack bit");
    step(1,1,0,0,0,ACK_0 ,2'b00,0,0,3'b000, 3'b000,3'b000,0,0, "R6 abort autoclear");
    step(1,1,1,0,1,ACK_0 ,2'b00,0,0,3'b000, 3'b000,3'b010,0,1, "R2 lost to line1");
    step(1,1,1,0,0,ACK_LO,2'b00,0,0,3'b000, 3'b000,3'b010,0,1, "R7 lost ignores ack");
    step(1,1,1,0,0,ACK_0 ,2'b00,0,0,3'b000, 3'b000,3'b010,0,1, "R7 lost ignores ack fall");
    step(1,1,1,0,0,ACK_0 ,2'b00,1,1,3'b001, 3'b000,3'b010,0,1, "R10 clear of unset bit");
    step(1,1,1,0,0,ACK_0 ,2'b00,1,0,3'b010, 3'b000,3'b010,0,1, "R10 clear of other line");
    step(1,1,1,0,0,ACK_0 ,2'b00,1,1,3'b010, 3'b000,3'b000,0,0, "R3 R7 lost w1c");
    step(1,1,0,0,1,ACK_0 ,2'b00,0,0,3'b000, 3'b010,3'b000,1,0, "R3 lost line0");
    step(1,1,0,0,0,ACK_0 ,2'b01,0,0,3'b000, 3'b110,3'b000,1,0, "R8 mailbox mirror");
    step(1,1,0,0,0,ACK_0 ,2'b01,1,0,3'b010, 3'b100,3'b000,0,0, "R4 retrigger gap");
    step(1,1,0,0,0,ACK_0 ,2'b01,0,0,3'b000, 3'b100,3'b000,1,0, "R4 retrigger return");
    step(1,1,0,0,0,ACK_0 ,2'b01,1,0,3'b100, 3'b100,3'b000,1,0, "R8 mailbox ignores w1c");
    step(1,1,0,0,0,ACK_0 ,2'b00,0,0,3'b000, 3'b000,3'b000,0,0, "R3 R8 mailbox drop");
    step(1,0,0,0,1,ACK_0 ,2'b00,0,0,3'b000, 3'b010,3'b000,0,0, "R5 masked lost");
    step(1,1,0,0,0,ACK_0 ,2'b00,0,0,3'b000, 3'b010,3'b000,1,0, "R5 unmask lost");
    step(1,1,0,0,0,ACK_0 ,2'b00,1,0,3'b010, 3'b000,3'b000,0,0, "R3 clear last flag");
    step(1,1,1,0,1,ACK_0 ,2'b00,1,1,3'b010, 3'b000,3'b010,0,1, "R9 set beats clear");
    step(1,1,1,0,0,ACK_0 ,2'b00,1,1,3'b010, 3'b000,3'b000,0,0, "R9 later clear");
    step(1,1,1,1,0,ACK_LO,2'b00,0,0,3'b000, 3'b000,3'b001,0,1, "R2 abort to line1");
    step(1,1,1,0,0,ACK_LO,2'b00,1,1,3'b001, 3'b000,3'b000,0,0, "R6 abort w1c");
    step(0,1,1,1,0,ACK_LO,2'b10,0,0,3'b000, 3'b000,3'b101,0,1, "R5 R8 masked abort mailbox line1");
    step(0,1,1,0,0,ACK_LO,2'b00,0,0,3'b000, 3'b000,3'b001,0,0, "R5 masked abort alone");
    step(1,1,1,0,0,ACK_0 ,2'b00,0,0,3'b000, 3'b000,3'b000,0,0, "R6 autoclear line1");
    step(1,1,0,0,0,ACK_0 ,2'b00,0,0,3'b000, 3'b000,3'b000,0,0, "R1 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule